// File: doc/BRIEF.md
# Microprogrammed Multi-Cycle Control Sequencer

This block steers the datapath of a multi-cycle 32-bit load/store processor subset. A 4-bit micro-program counter selects one of twelve 32-bit control words held in a read-only control store. Every datapath control output comes straight from fields of the current control word. The 2-bit sequencing field of that word chooses the next micro-address. It can advance by one, return to fetch, or jump through one of two opcode-indexed dispatch tables.

Each instruction starts at fetch (address 0) and moves to decode (address 1). From decode, the first dispatch table sends it to the routine for its instruction class. Memory instructions compute their address at step 2. The second dispatch table then splits them into the load routine and the store routine. The last step of every routine returns to fetch.

The PC write enable is the unconditional write bit ORed with the conditional bit ANDed with the ALU zero flag. Branch resolution therefore needs no extra sequencing state.

Top module: `ucode_ctrl_seq`

## Requirements
- R1: A synchronous active-high `rst` puts `upc` at 0. In the cycle after reset releases, `upc` is still 0, and the fetch controls are active: `mem_re`=1, `ir_we`=1, `pc_we`=1, `addr_sel`=0, `alu_b_sel`=2'b01 (constant 4), `alu_op`=2'b00 (add), `pc_src`=2'b00 (ALU result).
- R2: From address 0 the sequencer always advances to address 1 (decode). At decode it drives `alu_b_sel`=2'b11 (immediate times 4), `alu_a_sel`=0, and no write enables.
- R3: At decode the next address comes from the first dispatch table. Opcode 0x23 or 0x2B goes to 2, opcode 0x00 goes to 6, opcode 0x04 goes to 10, opcode 0x02 goes to 11, and any other opcode goes to 8.
- R4: At address 2 the next address comes from the second dispatch table. Opcode 0x23 goes to 3, opcode 0x2B goes to 5, and any other opcode goes to 0. Address 2 drives `addr_sel`=1 with no memory access.
- R5: A load (0x23) visits addresses 0,1,2,3,4 and then returns to 0, which is 5 cycles. Addresses 3 and 4 both hold `mem_re`=1, `addr_sel`=1 and `alu_b_sel`=2'b10. Only address 4 asserts `reg_we`, with `wdata_sel`=1 (memory data) and `reg_dst_sel`=0.
- R6: A store (0x2B) visits 0,1,2,5, which is 4 cycles. Address 5 asserts `mem_we`=1 with `addr_sel`=1, `mem_re`=0 and `reg_we`=0.
- R7: An R-type instruction (0x00) visits 0,1,6,7, which is 4 cycles. Both steps use `alu_op`=2'b10 (function field) and `alu_b_sel`=2'b00. Address 7 asserts `reg_we` with `reg_dst_sel`=1 and `wdata_sel`=0.
- R8: An immediate instruction (any unlisted opcode) visits 0,1,8,9, which is 4 cycles. It uses `alu_b_sel`=2'b10, and address 9 asserts `reg_we` with `reg_dst_sel`=0 and `wdata_sel`=0.
- R9: A branch (0x04) visits 0,1,10, which is 3 cycles. At address 10, `alu_op`=2'b01 (subtract) and `pc_src`=2'b01 (ALU output register), and `pc_we` equals `alu_zero`.
- R10: A jump (0x02) visits 0,1,11, which is 3 cycles. At address 11, `pc_src`=2'b10 (jump target) and `pc_we`=1 regardless of `alu_zero`.
- R11: `mem_we` and `mem_re` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction in the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| upc | output | 4 | Current micro-address |
| pc_src | output | 2 | Next-PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 immediate times 4 |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| reg_dst_sel | output | 1 | Write register: 0 rt field, 1 rd field |
| wdata_sel | output | 1 | Register write data: 0 ALU output register, 1 memory data |
| reg_we | output | 1 | Register file write enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_we | output | 1 | Memory write |
| mem_re | output | 1 | Memory read |
| ir_we | output | 1 | Instruction register write |
| pc_we | output | 1 | Effective PC write enable |

## Verification
The sequencer is driven with one opcode from each instruction class: load, store, R-type, branch and jump. The immediate class is driven with two different unlisted opcodes, which separates the default entry of the first dispatch table from the listed entries. Branches run once with the zero flag set and once with it clear, which shows that only the conditional term depends on the flag. A jump with the flag clear shows that the unconditional bit alone enables the PC write. In a further run the opcode changes after address-step dispatch to one that is neither load nor store, which reaches the default return of the second table. The per-step micro-address traces confirm the cycle count of each class.

// File: rtl/ucode_ctrl_seq.sv
module ucode_ctrl_seq #(
  parameter int UPC_W = 4,
  parameter int OPC_W = 6,
  parameter int UW_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic [UPC_W-1:0] upc,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op,
  output logic [1:0]       alu_b_sel,
  output logic             alu_a_sel,
  output logic             reg_dst_sel,
  output logic             wdata_sel,
  output logic             reg_we,
  output logic             addr_sel,
  output logic             mem_we,
  output logic             mem_re,
  output logic             ir_we,
  output logic             pc_we
);

  localparam logic [OPC_W-1:0] OP_RTYPE = OPC_W'(6'h00);
  localparam logic [OPC_W-1:0] OP_JUMP  = OPC_W'(6'h02);
  localparam logic [OPC_W-1:0] OP_BEQ   = OPC_W'(6'h04);
  localparam logic [OPC_W-1:0] OP_LOAD  = OPC_W'(6'h23);
  localparam logic [OPC_W-1:0] OP_STORE = OPC_W'(6'h2b);

  localparam logic [1:0] SEQ_INC  = 2'b00;
  localparam logic [1:0] SEQ_HOME = 2'b01;
  localparam logic [1:0] SEQ_TBL1 = 2'b10;

  function automatic logic [UW_W-1:0] store_word(input logic [UPC_W-1:0] a);
    case (a)
      4'h0: store_word = 32'h0103_4000;
      4'h1: store_word = 32'h8300_0000;
      4'h2: store_word = 32'hc288_0000;
      4'h3: store_word = 32'h028a_0000;
      4'h4: store_word = 32'h42ba_0000;
      4'h5: store_word = 32'h428c_0000;
      4'h6: store_word = 32'h0880_0000;
      4'h7: store_word = 32'h48d0_0000;
      4'h8: store_word = 32'h0280_0000;
      4'h9: store_word = 32'h4290_0000;
      4'ha: store_word = 32'h5480_8000;
      4'hb: store_word = 32'h6000_4000;
      default: store_word = 32'h4000_0000;
    endcase
  endfunction

  logic [UW_W-1:0]  uw;
  logic [UPC_W-1:0] tbl1, tbl2, upc_nxt;

  assign uw = store_word(upc);

  always_comb begin
    case (opcode)
      OP_LOAD, OP_STORE: tbl1 = UPC_W'(4'h2);
      OP_RTYPE:          tbl1 = UPC_W'(4'h6);
      OP_BEQ:            tbl1 = UPC_W'(4'ha);
      OP_JUMP:           tbl1 = UPC_W'(4'hb);
      default:           tbl1 = UPC_W'(4'h8);
    endcase
  end

  always_comb begin
    case (opcode)
      OP_LOAD:  tbl2 = UPC_W'(4'h3);
      OP_STORE: tbl2 = UPC_W'(4'h5);
      default:  tbl2 = '0;
    endcase
  end

  always_comb begin
    case (uw[31:30])
      SEQ_INC:  upc_nxt = upc + UPC_W'(1);
      SEQ_HOME: upc_nxt = '0;
      SEQ_TBL1: upc_nxt = tbl1;
      default:  upc_nxt = tbl2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_nxt;
  end

  assign pc_src      = uw[29:28];
  assign alu_op      = uw[27:26];
  assign alu_b_sel   = uw[25:24];
  assign alu_a_sel   = uw[23];
  assign reg_dst_sel = uw[22];
  assign wdata_sel   = uw[21];
  assign reg_we      = uw[20];
  assign addr_sel    = uw[19];
  assign mem_we      = uw[18];
  assign mem_re      = uw[17];
  assign ir_we       = uw[16];
  assign pc_we       = uw[14] | (uw[15] & alu_zero);

endmodule

// File: rtl/ucode_ctrl_seq_chk.sv
module ucode_ctrl_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic       alu_zero,
  input logic [3:0] upc,
  input logic [1:0] pc_src,
  input logic       mem_we,
  input logic       mem_re,
  input logic       ir_we,
  input logic       pc_we
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  reset_home_chk: assert property (@(posedge clk) rst_q === 1'b1 |-> upc == 4'h0);

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 4'h0 |=> upc == 4'h1);

  // R3
  decode_target_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 4'h1 |=> (upc inside {4'h2, 4'h6, 4'h8, 4'ha, 4'hb}));

  // R5
  load_step_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 4'h3 |=> upc == 4'h4);

  // R9
  branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 4'ha |-> (pc_we == alu_zero && pc_src == 2'b01));

  // R10
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 4'hb |-> (pc_we && pc_src == 2'b10));

  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R1
  ir_fetch_only_chk: assert property (@(posedge clk) disable iff (rst)
    ir_we |-> upc == 4'h0);

endmodule

bind ucode_ctrl_seq ucode_ctrl_seq_chk u_chk (.*);

// File: tb/tb_ucode_ctrl_seq.sv
module tb_ucode_ctrl_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       alu_zero = 1'b0;
  logic [3:0] upc;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic       alu_a_sel, reg_dst_sel, wdata_sel, reg_we, addr_sel;
  logic       mem_we, mem_re, ir_we, pc_we;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ucode_ctrl_seq dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fetch_decode(input logic [5:0] op, input logic z);
    opcode = op; alu_zero = z;
    chk("R2 fetch upc", upc, 0);
    chk("R1 fetch ctl", {mem_re, ir_we, pc_we, addr_sel, alu_b_sel, alu_op, pc_src}, 10'b1110_01_00_00);
    @(negedge clk);
    chk("R2 decode upc", upc, 1);
    chk("R2 decode ctl", {alu_b_sel, alu_a_sel, reg_we, mem_we, mem_re, ir_we, pc_we}, 8'b11_000000);
    @(negedge clk);
  endtask

  task automatic t_load();
    fetch_decode(6'h23, 1'b0);
    chk("R3 load target", upc, 2);
    chk("R4 addr step", {addr_sel, mem_re, mem_we}, 3'b100);
    @(negedge clk);
    chk("R4 load target", upc, 3);
    chk("R5 step3", {mem_re, addr_sel, alu_b_sel, reg_we}, 5'b11_10_0);
    @(negedge clk);
    chk("R5 step4 upc", upc, 4);
    chk("R5 step4", {mem_re, addr_sel, alu_b_sel, reg_we, wdata_sel, reg_dst_sel}, 7'b11_10_110);
    @(negedge clk);
    chk("R5 return", upc, 0);
  endtask

  task automatic t_store();
    fetch_decode(6'h2b, 1'b1);
    chk("R3 store target", upc, 2);
    @(negedge clk);
    chk("R4 store target", upc, 5);
    chk("R6 store ctl", {mem_we, addr_sel, mem_re, reg_we}, 4'b1100);
    @(negedge clk);
    chk("R6 return", upc, 0);
  endtask

  task automatic t_rtype();
    fetch_decode(6'h00, 1'b0);
    chk("R3 rtype target", upc, 6);
    chk("R7 step1", {alu_op, alu_b_sel, reg_we}, 5'b10_00_0);
    @(negedge clk);
    chk("R7 step2 upc", upc, 7);
    chk("R7 step2", {alu_op, alu_b_sel, reg_we, reg_dst_sel, wdata_sel}, 7'b10_00_110);
    @(negedge clk);
    chk("R7 return", upc, 0);
  endtask

  task automatic t_imm(input logic [5:0] op);
    fetch_decode(op, 1'b0);
    chk("R3 imm target", upc, 8);
    chk("R8 step1", {alu_b_sel, reg_we}, 3'b10_0);
    @(negedge clk);
    chk("R8 step2 upc", upc, 9);
    chk("R8 step2", {alu_b_sel, reg_we, reg_dst_sel, wdata_sel}, 5'b10_100);
    @(negedge clk);
    chk("R8 return", upc, 0);
  endtask

  task automatic t_branch(input logic z);
    fetch_decode(6'h04, z);
    chk("R3 branch target", upc, 10);
    chk("R9 branch ctl", {alu_op, pc_src, pc_we}, {4'b01_01, z});
    @(negedge clk);
    chk("R9 return", upc, 0);
  endtask

  task automatic t_jump();
    fetch_decode(6'h02, 1'b0);
    chk("R3 jump target", upc, 11);
    chk("R10 jump ctl", {pc_src, pc_we}, 3'b10_1);
    @(negedge clk);
    chk("R10 return", upc, 0);
  endtask

  task automatic t_tbl2_default();
    fetch_decode(6'h23, 1'b0);
    chk("R3 mem target", upc, 2);
    opcode = 6'h04;
    @(negedge clk);
    chk("R4 default to fetch", upc, 0);
  endtask

  task automatic t_reset_mid();
    fetch_decode(6'h00, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-instr", upc, 0);
  endtask

  always @(negedge clk) if (!rst && mem_we && mem_re) chk("R11 exclusive", 1, 0);

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset upc", upc, 0);
    t_load();
    t_store();
    t_rtype();
    t_imm(6'h08);
    t_imm(6'h0d);
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_tbl2_default();
    t_reset_mid();
    t_load();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule